// File: doc/BRIEF.md
# Serial-Loaded Latched Output Controller

This block is the logic front end of an eight-channel low-side switch. A host shifts on/off data in over three wires: a serial clock, a serial data line and a strobe. Each rising edge of the serial clock pushes one bit into a shift register with one stage per channel. While the strobe is high, a holding buffer follows the shift register. When the strobe falls, the buffer keeps the last value. An active-low enable masks all channel-on outputs together. It leaves the stored data alone.

The bit that leaves the last stage appears on a serial data output, so several devices can share one serial clock and one strobe. For example, an 8-channel device that feeds a 10-channel device is loaded with 18 clocks and then one shared strobe. The whole block runs on one system clock. The serial clock, data, strobe and enable inputs pass through synchronizers, and the block detects their edges internally. A synchronous active-high reset stands in for power-on reset and turns every channel off.

Top module: `serial_latch_driver`

## Requirements
- R1: In the first cycle after reset is released, `chan_on` is all zeros and `sdata_out` is 0.
- R2: The shift register has exactly CH_COUNT stages. It moves by one position only on a detected rising edge of `sclk_in`, and it takes in the value `sdata_in` had at that edge.
- R3: While `strobe_in` stays low, shifting does not change `chan_on`.
- R4: While `strobe_in` is high, `chan_on` follows the shift register contents, including bits shifted in while the strobe is high.
- R5: After `strobe_in` falls, the buffer and `chan_on` keep the captured value while later bits are shifted in.
- R6: While `enable_n` is 1, every bit of `chan_on` is 0, whatever the buffer holds. When `enable_n` returns to 0, the buffered value reappears unchanged.
- R7: `chan_on[k]` is 1 when buffer bit k is 1 and 0 when it is 0. The first of CH_COUNT bits shifted in ends in bit CH_COUNT-1, and the last one ends in bit 0. So sending a byte most significant bit first gives `chan_on` equal to that byte.
- R8: `sdata_out` shows the content of the last stage (bit CH_COUNT-1). It changes only after a detected falling edge of `sclk_in`.
- R9: The level of `enable_n` has no effect on shifting or on latching. Data loaded while the block is disabled shows up once it is enabled.
- R10: When a device's `sdata_out` feeds the `sdata_in` of a second device, and both devices share the clock and the strobe, the pair acts as one shift register whose length is the sum of their lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sclk_in | input | 1 | Serial clock, asynchronous to clk |
| sdata_in | input | 1 | Serial data, sampled on the rising edge of the serial clock |
| strobe_in | input | 1 | Buffer follows the shift register while high and holds while low |
| enable_n | input | 1 | Active-low output enable |
| sdata_out | output | 1 | Last-stage bit, for chaining devices |
| chan_on | output | CH_COUNT | Channel-on signals, 1 = on |

## Verification
The assertions assume that `sclk_in`, `strobe_in` and `enable_n` each hold a level for several system clocks, so that the synchronizers see every edge. They also assume that `sdata_in` is settled a few cycles before each serial clock rise and stays there until after it. The bench drives every serial clock phase for six system cycles and changes data three cycles before each rise. It also gives the strobe and enable ten or more cycles per level. Values are sampled only after the synchronizer and output register latency has passed.

// File: rtl/serial_latch_pkg.sv
package serial_latch_pkg;
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_info_t;
endpackage

// File: rtl/serial_latch_sync.sv
module serial_latch_sync
  import serial_latch_pkg::*;
#(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  output edge_info_t ev
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= chain[STAGES-1];
  end

  always_comb begin
    ev.lvl  = chain[STAGES-1];
    ev.rise = chain[STAGES-1] & ~prev;
    ev.fall = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/serial_latch_shift.sv
module serial_latch_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             out_en,
  input  logic             din,
  output logic [WIDTH-1:0] q,
  output logic             sdo
);
  localparam int LAST = WIDTH - 1;

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[LAST-1:0], din};
  end

  // serial out moves on the serial clock's falling edge for downstream hold
  always_ff @(posedge clk) begin
    if (rst)         sdo <= 1'b0;
    else if (out_en) sdo <= q[LAST];
  end
endmodule

// File: rtl/serial_latch_out.sv
module serial_latch_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             follow,
  input  logic             drive_ok,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] chan_on
);
  // level-sensitive buffer modelled as a clock-enabled register
  always_ff @(posedge clk) begin
    if (rst)         latch_q <= '0;
    else if (follow) latch_q <= d;
  end

  always_ff @(posedge clk) begin
    if (rst)           chan_on <= '0;
    else if (drive_ok) chan_on <= latch_q;
    else               chan_on <= '0;
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import serial_latch_pkg::*;
#(
  parameter int CH_COUNT    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_in,
  input  logic                sdata_in,
  input  logic                strobe_in,
  input  logic                enable_n,
  output logic                sdata_out,
  output logic [CH_COUNT-1:0] chan_on
);
  edge_info_t sclk_ev, data_ev, strb_ev, en_ev;
  logic sclk_rise, sclk_fall;
  logic [CH_COUNT-1:0] shift_q, latch_q;

  serial_latch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .din(sclk_in), .ev(sclk_ev));
  serial_latch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_data (
    .clk(clk), .rst(rst), .din(sdata_in), .ev(data_ev));
  serial_latch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_strb (
    .clk(clk), .rst(rst), .din(strobe_in), .ev(strb_ev));
  serial_latch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
    .clk(clk), .rst(rst), .din(enable_n), .ev(en_ev));

  assign sclk_rise = sclk_ev.rise;
  assign sclk_fall = sclk_ev.fall;

  serial_latch_shift #(.WIDTH(CH_COUNT)) u_shift (
    .clk(clk), .rst(rst), .shift_en(sclk_rise), .out_en(sclk_fall),
    .din(data_ev.lvl), .q(shift_q), .sdo(sdata_out));

  serial_latch_out #(.WIDTH(CH_COUNT)) u_out (
    .clk(clk), .rst(rst), .follow(strb_ev.lvl), .drive_ok(~en_ev.lvl),
    .d(shift_q), .latch_q(latch_q), .chan_on(chan_on));
endmodule

// File: rtl/serial_latch_driver_chk.sv
module serial_latch_driver_chk #(
  parameter int CH_COUNT    = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                strobe_in,
  input logic                enable_n,
  input logic                sdata_out,
  input logic [CH_COUNT-1:0] chan_on,
  input logic                sclk_rise,
  input logic                sclk_fall,
  input logic [CH_COUNT-1:0] shift_q,
  input logic [CH_COUNT-1:0] latch_q
);
  localparam int LIM = SYNC_STAGES + 3;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] dis_cnt, low_cnt;
  logic          rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst || !enable_n) dis_cnt <= '0;
    else if (dis_cnt != CW'(LIM)) dis_cnt <= dis_cnt + 1'b1;
    if (rst || strobe_in) low_cnt <= '0;
    else if (low_cnt != CW'(LIM)) low_cnt <= low_cnt + 1'b1;
  end

  // R1: outputs off straight after reset
  a_r1_reset_off: assert property (@(posedge clk)
    (rst_d && !rst) |-> (chan_on == '0 && sdata_out == 1'b0));

  // R2: register moves only on a detected serial clock rise
  a_r2_shift_on_rise: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(shift_q));

  // R3 / R5: buffer holds while strobe has been low long enough
  a_r5_hold_low: assert property (@(posedge clk) disable iff (rst)
    (low_cnt == CW'(LIM)) |=> $stable(latch_q));

  // R6: long enough disabled means all channels off
  a_r6_enable_mask: assert property (@(posedge clk) disable iff (rst)
    (dis_cnt == CW'(LIM)) |-> (chan_on == '0));

  // R8: serial out changes only after a serial clock fall
  a_r8_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(sdata_out));
endmodule

bind serial_latch_driver serial_latch_driver_chk #(
  .CH_COUNT(CH_COUNT), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .strobe_in(strobe_in), .enable_n(enable_n),
  .sdata_out(sdata_out), .chan_on(chan_on), .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall), .shift_q(shift_q), .latch_q(latch_q)
);

// File: tb/sim_serial_latch_driver.sv
module sim_serial_latch_driver;
  localparam int CLK_PERIOD = 10;
  localparam int N0 = 8;
  localparam int N1 = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, strb = 1'b0, en_n = 1'b0;
  logic sdo0, sdo1;
  logic [N0-1:0] chan0;
  logic [N1-1:0] chan1;

  int total = 0, bad = 0;
  bit done = 0;

  logic [N0-1:0] m0, b0;
  logic [N1-1:0] m1, b1;
  bit strobe_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_latch_driver #(.CH_COUNT(N0)) u0 (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(sdi), .strobe_in(strb),
    .enable_n(en_n), .sdata_out(sdo0), .chan_on(chan0));

  serial_latch_driver #(.CH_COUNT(N1)) u1 (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(sdo0), .strobe_in(strb),
    .enable_n(en_n), .sdata_out(sdo1), .chan_on(chan1));

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N0-1:0] exp0();
    return en_n ? '0 : b0;
  endfunction

  function automatic logic [N1-1:0] exp1();
    return en_n ? '0 : b1;
  endfunction

  task automatic send_bit(input logic b);
    sdi = b;
    wait_clk(3);
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
    wait_clk(6);
    m1 = {m1[N1-2:0], m0[N0-1]};
    m0 = {m0[N0-2:0], b};
    if (strobe_hi) begin b0 = m0; b1 = m1; end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_strobe();
    strb = 1'b1; strobe_hi = 1; b0 = m0; b1 = m1;
    wait_clk(10);
    strb = 1'b0; strobe_hi = 0;
    wait_clk(10);
  endtask

  initial begin
    int unused_seed;
    logic [7:0] r;
    logic [17:0] pat;
    unused_seed = $urandom(32'h5eed);
    m0 = '0; m1 = '0; b0 = '0; b1 = '0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    chk("R1 chan_on after reset", 32'(chan0), 0);
    chk("R1 sdata_out after reset", 32'(sdo0), 0);
    chk("R1 chained chan_on after reset", 32'(chan1), 0);

    // R3: shift with strobe low, outputs unchanged
    send_byte(8'hA5);
    chk("R3 no change while strobe low", 32'(chan0), 0);
    chk("R8 sdata_out is last stage", 32'(sdo0), 32'(m0[N0-1]));

    // R4: strobe high, follows, including later shifts
    strb = 1'b1; strobe_hi = 1; b0 = m0; b1 = m1;
    wait_clk(8);
    chk("R4 follows while strobe high", 32'(chan0), 32'(exp0()));
    chk("R7 byte msb-first maps to chan_on", 32'(chan0), 32'h A5);
    send_bit(1'b0);
    chk("R4 follows new shift while strobe high", 32'(chan0), 32'(exp0()));
    strb = 1'b0; strobe_hi = 0;
    wait_clk(8);

    // R5: held after strobe falls
    send_byte(8'h3C);
    chk("R5 held after strobe falls", 32'(chan0), 32'(exp0()));
    chk("R5 held value check", 32'(chan0), 32'h4A);

    // R7 directed: first bit lands in top channel
    send_bit(1'b1);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    pulse_strobe();
    chk("R7 first bit drives top channel", 32'(chan0), 32'h80);
    send_byte(8'hFF); pulse_strobe();
    chk("R7 all ones", 32'(chan0), 32'hFF);
    send_byte(8'h00); pulse_strobe();
    chk("R7 all zeros", 32'(chan0), 32'h00);

    // R6 / R9: enable masks, shifting and latching still work
    send_byte(8'h0F); pulse_strobe();
    en_n = 1'b1;
    wait_clk(8);
    chk("R6 enable high forces off", 32'(chan0), 0);
    send_byte(8'hC3); pulse_strobe();
    chk("R6 still off while disabled", 32'(chan0), 0);
    en_n = 1'b0;
    wait_clk(8);
    chk("R9 data loaded while disabled appears", 32'(chan0), 32'hC3);

    // R10: 18-bit cascaded load across two devices
    pat = 18'h2D3A7;
    for (int i = 17; i >= 0; i--) send_bit(pat[i]);
    pulse_strobe();
    chk("R10 downstream device", 32'(chan1), 32'(pat[17:8]));
    chk("R10 upstream device", 32'(chan0), 32'(pat[7:0]));
    chk("R10 model agreement", 32'(chan1), 32'(exp1()));

    // random mix
    for (int k = 0; k < 20; k++) begin
      r = 8'($urandom);
      en_n = 1'($urandom);
      wait_clk(6);
      send_byte(r);
      chk("R8 sdata_out random", 32'(sdo0), 32'(m0[N0-1]));
      if ($urandom % 2) begin
        pulse_strobe();
        chk("R7 random latch", 32'(chan0), 32'(en_n ? 8'h00 : r));
      end else begin
        chk("R3 random no strobe", 32'(chan0), 32'(exp0()));
      end
      chk("R10 random chained", 32'(chan1), 32'(exp1()));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule